// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous static memory. Its data bus can change direction between reads and writes on back-to-back cycles with no idle cycle in between. On every clock edge it registers the address, the control inputs and the per-lane write selects. The data transfer that belongs to them happens during the following cycle.

Read data is not registered. It flows from the storage array to the data outputs while the read's data cycle is in progress. Write data is taken from the bus at the edge that closes its data cycle and is stored at that edge. A read issued on the next cycle to the same word therefore already sees the new value.

When the load input is high, the cycle is a burst continuation. A small sequencer produces the next address within an aligned group of four words, in either linear or interleaved order chosen by a parameter. The operation type and the select state are the ones captured at the last load. The bus is split into input, output and drive-enable signals so that the pad ring can build the tristate driver.

Top module: `zbt_sram`

## Requirements
- R1: Address and control are sampled at a rising edge where `hold` is low. The data phase of that operation is the clock cycle that follows, and write data is taken from `dq_in` at the rising edge that ends that data phase.
- R2: During the data phase of a read, `dq_out` shows the stored word at the read address without any added register stage, and `dq_oe` is 1 while `oe_n` is 0.
- R3: Reads and writes may be issued on consecutive cycles in either order with no idle cycle. A read issued in the cycle right after a write's data phase, to the same address, returns the newly written word.
- R4: `oe_n` is asynchronous. While it is 1, `dq_oe` is 0 with no clock edge needed, and driving it back to 0 restores the drive at once.
- R5: At a rising edge where `hold` is 1, all synchronous inputs are ignored and all internal state is kept. A pending read keeps driving the same data, and a pending write is not stored until the next edge where `hold` is 0.
- R6: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load cycle (`load_n`=0) in which any of these is inactive starts no operation. A transfer already in its data phase still completes.
- R7: `dq_oe` is 0 during the cycle after a deselecting load and during the data phase of every write.
- R8: The word is `LANES` lanes of `LANE_W` bits, and lane i occupies bits [i*LANE_W+LANE_W-1 : i*LANE_W]. A write updates lane i only if `lane_wr_n[i]`=0 was sampled with that write's control. Other lanes keep their stored bits.
- R9: A cycle with `load_n`=1 continues the burst with the operation type and select state of the last load. For address A loaded, step k (k=0..3) uses address A with its two low bits replaced by (A[1:0]+k) mod 4 when `INTERLEAVE`=0, or by A[1:0] XOR k when `INTERLEAVE`=1.
- R10: While `rst_n` is 0 and after its release, no operation is pending and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control state |
| hold | input | 1 | 1 suspends the block: inputs ignored, state kept |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write (sampled on load cycles) |
| load_n | input | 1 | 0 = load new address and operation, 1 = advance burst |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data to the bus |
| dq_oe | output | 1 | 1 = the block drives the bus |

## Verification
The bench alternates writes and reads to the same word on consecutive cycles. A design that stored write data one edge late, or that added an output register, would return the old word or lag by a cycle. It stalls a write in its data phase with wrong data on the bus, which would corrupt the word if `hold` failed to freeze the commit. It also stalls a read to confirm that the output stays fixed. It drives linear bursts that wrap inside a four-word group, so a counter carrying into the upper address bits would read the wrong word. It also checks partial lane writes, each of the three selects on its own, and the completion of a pending write after deselection. A design that dropped the pending transfer or decoded a select with the wrong polarity would leave a stale word or drive the bus when it should not.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;

   // Selected only when every one of the three enables is in its active state
   function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
      return (~a_n) & b & (~c_n);
   endfunction

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
   parameter int ADDR_W     = 6,
   parameter int BURST_LEN  = 4,
   parameter bit INTERLEAVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int CNT_W = $clog2(BURST_LEN);

   logic [ADDR_W-1:0] base_q, base_nx;
   logic [CNT_W-1:0]  cnt_q, cnt_nx;
   logic [CNT_W-1:0]  low;

   always_comb begin
      base_nx = load ? addr_in : base_q;
      cnt_nx  = load ? '0 : cnt_q + 1'b1;
   end

   generate
      if (INTERLEAVE) begin : g_interleave
         assign low = base_nx[CNT_W-1:0] ^ cnt_nx;
      end else begin : g_linear
         assign low = base_nx[CNT_W-1:0] + cnt_nx;
      end
   endgenerate

   assign addr_out = {base_nx[ADDR_W-1:CNT_W], low};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (en) begin
         base_q <= base_nx;
         cnt_q  <= cnt_nx;
      end
   end

endmodule

// File: rtl/zbt_ctrl_pipe.sv
module zbt_ctrl_pipe
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic              sel,
   input  op_e               op_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [LANES-1:0]  lane_n,
   output logic              act_q,
   output op_e               op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LANES-1:0]  lane_q
);

   logic burst_act_q;
   op_e  burst_op_q;
   logic act_d;
   op_e  op_d;

   always_comb begin
      act_d = load ? sel   : burst_act_q;
      op_d  = load ? op_in : burst_op_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q       <= 1'b0;
         op_q        <= OP_READ;
         addr_q      <= '0;
         lane_q      <= '0;
         burst_act_q <= 1'b0;
         burst_op_q  <= OP_READ;
      end else if (en) begin
         act_q  <= act_d;
         op_q   <= op_d;
         addr_q <= addr_in;
         lane_q <= ~lane_n;
         if (load) begin
            burst_act_q <= sel;
            burst_op_q  <= op_in;
         end
      end
   end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we && lane_en[g])
               mem[addr] <= wdata[g*LANE_W +: LANE_W];
         end

         // flow-through read: no output register
         assign rdata[g*LANE_W +: LANE_W] = mem[addr];
      end
   endgenerate

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   parameter int BURST_LEN  = 4,
   parameter bit INTERLEAVE = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    rd_wr_n,
   input  logic                    load_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    oe_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int DATA_W = LANES * LANE_W;
   localparam int CNT_W  = $clog2(BURST_LEN);

   generate
      if (BURST_LEN < 2 || (1 << CNT_W) != BURST_LEN) begin : g_bad_burst
         $error("BURST_LEN must be a power of two of at least 2");
      end
      if (ADDR_W <= CNT_W) begin : g_bad_addr
         $error("ADDR_W must exceed the burst counter width");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("LANES and LANE_W must be positive");
      end
   endgenerate

   logic              run;
   logic              load;
   logic [ADDR_W-1:0] seq_addr;
   logic              act_q;
   op_e               op_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  lane_q;
   logic [DATA_W-1:0] rdata;

   assign run  = ~hold;
   assign load = ~load_n;

   zbt_burst_seq #(
      .ADDR_W    (ADDR_W),
      .BURST_LEN (BURST_LEN),
      .INTERLEAVE(INTERLEAVE)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (run),
      .load    (load),
      .addr_in (addr),
      .addr_out(seq_addr)
   );

   zbt_ctrl_pipe #(
      .ADDR_W(ADDR_W),
      .LANES (LANES)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (run),
      .load   (load),
      .sel    (chip_selected(sel_a_n, sel_b, sel_c_n)),
      .op_in  (rd_wr_n ? OP_READ : OP_WRITE),
      .addr_in(seq_addr),
      .lane_n (lane_wr_n),
      .act_q  (act_q),
      .op_q   (op_q),
      .addr_q (addr_q),
      .lane_q (lane_q)
   );

   assign wr_q = (op_q == OP_WRITE);

   zbt_array #(
      .ADDR_W(ADDR_W),
      .LANES (LANES),
      .LANE_W(LANE_W)
   ) u_array (
      .clk    (clk),
      .we     (run & act_q & wr_q),
      .lane_en(lane_q),
      .addr   (addr_q),
      .wdata  (dq_in),
      .rdata  (rdata)
   );

   assign dq_out = rdata;
   assign dq_oe  = act_q & ~wr_q & ~oe_n;

endmodule

module zbt_sram_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold,
   input logic              load_n,
   input logic              rd_wr_n,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic              oe_n,
   input logic              dq_oe,
   input logic              act_q,
   input logic              wr_q,
   input logic [ADDR_W-1:0] addr_q
);

   logic sel_ok;
   assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

   p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

   p_desel_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !load_n && !sel_ok) |=> !dq_oe);

   p_write_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !load_n && sel_ok && !rd_wr_n) |=> !dq_oe);

   p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !load_n && sel_ok && rd_wr_n) |=> (dq_oe || oe_n));

   p_hold_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(act_q) && $stable(wr_q) && $stable(addr_q)));

   p_burst_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && load_n) |=> ($stable(act_q) && $stable(wr_q)));

endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .hold   (hold),
   .load_n (load_n),
   .rd_wr_n(rd_wr_n),
   .sel_a_n(sel_a_n),
   .sel_b  (sel_b),
   .sel_c_n(sel_c_n),
   .oe_n   (oe_n),
   .dq_oe  (dq_oe),
   .act_q  (act_q),
   .wr_q   (wr_q),
   .addr_q (addr_q)
);

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;

   localparam int AW = 6;
   localparam int DW = 36;
   localparam logic RD = 1'b1;
   localparam logic WR = 1'b0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hold = 1'b0;
   logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic          rd_wr_n = 1'b1;
   logic          load_n = 1'b0;
   logic [3:0]    lane_wr_n = 4'hF;
   logic          oe_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   int checks = 0;
   int bad = 0;

   always #5 clk = ~clk;

   zbt_sram u_dut (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .rd_wr_n(rd_wr_n), .load_n(load_n), .lane_wr_n(lane_wr_n),
      .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // dsel: 0 selected, 1 sel_a_n off, 2 sel_b off, 3 sel_c_n off
   task automatic step(input logic ld_n, input logic rw, input logic [AW-1:0] a,
                       input logic [3:0] bw_n, input int dsel, input logic [DW-1:0] din,
                       input logic hld);
      load_n    = ld_n;
      rd_wr_n   = rw;
      addr      = a;
      lane_wr_n = bw_n;
      sel_a_n   = (dsel == 1);
      sel_b     = (dsel != 2);
      sel_c_n   = (dsel == 3);
      dq_in     = din;
      hold      = hld;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ld(input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] din);
      step(1'b0, rw, a, 4'h0, 0, din, 1'b0);
   endtask

   task automatic idle(input logic [DW-1:0] din);
      step(1'b0, RD, '0, 4'h0, 2, din, 1'b0);
   endtask

   task automatic adv(input logic [DW-1:0] din);
      step(1'b1, RD, '0, 4'h0, 0, din, 1'b0);
   endtask

   task automatic t_reset;
      chk("R10 no drive after reset", {35'd0, dq_oe}, 36'd0);
      idle('0);
      chk("R10 idle keeps bus released", {35'd0, dq_oe}, 36'd0);
   endtask

   task automatic t_alternate;
      ld(WR, 6'd5, '0);
      chk("R7 released in write data phase", {35'd0, dq_oe}, 36'd0);
      ld(RD, 6'd5, 36'h1_2345_6789);
      chk("R3 read right after write drives", {35'd0, dq_oe}, 36'd1);
      chk("R3 read right after write data", dq_out, 36'h1_2345_6789);
      ld(WR, 6'd6, '0);
      chk("R7 release on read-to-write turn", {35'd0, dq_oe}, 36'd0);
      ld(RD, 6'd6, 36'hA_BCDE_F012);
      chk("R3 write-read alternation", dq_out, 36'hA_BCDE_F012);
      ld(RD, 6'd5, '0);
      chk("R2 flow-through read", dq_out, 36'h1_2345_6789);
      ld(WR, 6'd7, '0);
      idle(36'h5_5555_AAAA);
      ld(RD, 6'd7, '0);
      chk("R1 write data taken in data cycle", dq_out, 36'h5_5555_AAAA);
      idle('0);
   endtask

   task automatic t_lanes;
      ld(WR, 6'd8, '0);
      step(1'b0, WR, 6'd8, 4'b1010, 0, 36'hF_FFFF_FFFF, 1'b0);
      // data phase of the partial write: lanes 0 and 2 enabled
      ld(RD, 6'd8, 36'h0_0000_0000);
      chk("R8 partial lane write", dq_out, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
      idle('0);
   endtask

   task automatic t_oe;
      ld(RD, 6'd5, '0);
      oe_n = 1'b1;
      #1;
      chk("R4 oe_n high releases at once", {35'd0, dq_oe}, 36'd0);
      oe_n = 1'b0;
      #1;
      chk("R4 oe_n low drives again", {35'd0, dq_oe}, 36'd1);
      chk("R4 data intact", dq_out, 36'h1_2345_6789);
      idle('0);
   endtask

   task automatic t_select;
      for (int d = 1; d <= 3; d++) begin
         step(1'b0, RD, 6'd5, 4'h0, d, '0, 1'b0);
         chk($sformatf("R6 deselect by enable %0d", d), {35'd0, dq_oe}, 36'd0);
      end
      ld(WR, 6'd10, '0);
      step(1'b0, RD, 6'd0, 4'h0, 1, 36'h3_3333_0000, 1'b0);
      ld(RD, 6'd10, '0);
      chk("R6 pending write completes", dq_out, 36'h3_3333_0000);
      step(1'b0, WR, 6'd10, 4'h0, 3, '0, 1'b0);
      chk("R6 read completes before deselect", {35'd0, dq_oe}, 36'd0);
      idle(36'h9_9999_9999);
      ld(RD, 6'd10, '0);
      chk("R6 deselected write not started", dq_out, 36'h3_3333_0000);
      idle('0);
   endtask

   task automatic t_hold;
      ld(WR, 6'd40, '0);
      step(1'b0, WR, 6'd41, 4'h0, 0, 36'h6_6666_6666, 1'b1);
      ld(RD, 6'd40, 36'h0_1234_0000);
      chk("R5 held write stored after release", dq_out, 36'h0_1234_0000);
      step(1'b0, WR, 6'd41, 4'h0, 0, 36'h7_7777_7777, 1'b1);
      chk("R5 held read keeps driving", {35'd0, dq_oe}, 36'd1);
      chk("R5 held read keeps data", dq_out, 36'h0_1234_0000);
      ld(RD, 6'd41, '0);
      ld(RD, 6'd40, '0);
      chk("R5 ignored write left word intact", dq_out, 36'h0_1234_0000);
      idle('0);
   endtask

   task automatic t_burst;
      ld(WR, 6'd12, '0);
      ld(WR, 6'd13, 36'h0_0000_0C0C);
      ld(WR, 6'd14, 36'h0_0000_0D0D);
      ld(WR, 6'd15, 36'h0_0000_0E0E);
      idle(36'h0_0000_0F0F);
      ld(RD, 6'd14, '0);
      chk("R9 burst step 0", dq_out, 36'h0_0000_0E0E);
      adv('0);
      chk("R9 burst step 1", dq_out, 36'h0_0000_0F0F);
      adv('0);
      chk("R9 burst wraps in group", dq_out, 36'h0_0000_0C0C);
      adv('0);
      chk("R9 burst step 3", dq_out, 36'h0_0000_0D0D);
      ld(WR, 6'd20, '0);
      adv(36'h1_0000_0001);
      chk("R9 burst keeps write type", {35'd0, dq_oe}, 36'd0);
      adv(36'h1_0000_0002);
      adv(36'h1_0000_0003);
      idle(36'h1_0000_0004);
      ld(RD, 6'd20, '0);
      chk("R9 burst write word 0", dq_out, 36'h1_0000_0001);
      ld(RD, 6'd23, '0);
      chk("R9 burst write word 3", dq_out, 36'h1_0000_0004);
      idle('0);
      adv('0);
      chk("R9 advance keeps deselect", {35'd0, dq_oe}, 36'd0);
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      bad++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_pre();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alternate();
      t_lanes();
      t_oe();
      t_select();
      t_hold();
      t_burst();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   task automatic t_reset_pre;
      chk("R10 no drive during reset", {35'd0, dq_oe}, 36'd0);
   endtask

endmodule